// File: doc/BRIEF.md
# Block Cipher Chaining Mode Controller

This block is the chaining layer between a register front end and two block-cipher engines: a narrow engine with 64-bit blocks and a wide engine with 128-bit blocks. The front end supplies a chaining mode, an engine select, a direction, a key and one input block at a time. The controller forms the engine's input according to the chaining mode and launches the selected engine with a one-cycle start pulse. It waits for that engine's done strobe, combines the engine result with the chaining state, and returns the processed block with its own one-cycle valid pulse.

The chaining register holds either the previous ciphertext or the running counter. It is loaded from an initial value while the controller is idle and is visible on `chain_out`. A message ends with an end-of-message pulse. Once the final block has been handled, a sticky completion flag rises together with a one-cycle interrupt pulse, and from then on the chaining context can be read safely. A halt input from the error logic abandons the block in flight at once.

Top module: `chain_mode_ctrl`

## Requirements
- R1: After reset, `blk_ready`=1, `out_valid`=0, `msg_done`=0, `irq`=0, `chain_out`=0, and neither engine receives a start pulse.
- R2: When `cfg_wide`=1 the block and key go to the 128-bit engine, and when it is 0 they go to the 64-bit engine. The start, key and block inputs of the engine that is not selected stay zero.
- R3: An accepted block (`blk_valid`=1 while `blk_ready`=1, with `halt`=0 and `iv_load`=0) causes exactly one start pulse, on the selected engine only. A block offered while `blk_ready`=0 is ignored.
- R4: In 64-bit mode only bits [63:0] of the block, key, initial value and chaining register take part, and bits [127:64] of `out_blk` and `chain_out` are zero.
- R5: Mode encoding on `cfg_mode`: 2'b00 ECB, 2'b01 CBC, 2'b10 CTR, and 2'b11 behaves as ECB. In ECB the output is the engine result for the input block in the direction `cfg_decrypt` (1 = decrypt).
- R6: CBC encrypt sends block XOR chain to the engine, returns the engine result and stores it as the chain. CBC decrypt sends the block itself, returns engine result XOR chain, and stores the input block as the chain.
- R7: In CTR the engine always runs in the encrypt direction on the chain value. The output is block XOR engine result, and the chain then increments modulo 2^64 or 2^128 according to the selected width.
- R8: `out_valid` is a one-cycle pulse, and the new `chain_out` appears on the same cycle as `out_valid`.
- R9: `iv_load` while idle loads `chain_out` from `iv_in` (masked to the selected width) and clears `msg_done`.
- R10: If `eom` arrives while a block is in flight, `msg_done` rises one cycle after that block's `out_valid`. If `eom` arrives while idle, `msg_done` rises two clock edges after it. `irq` pulses for one cycle as `msg_done` rises, `msg_done` is never 1 while a block is in flight, and the next accepted block clears `msg_done`.
- R11: `halt` aborts a block in flight at once: no `out_valid` follows, a pending end-of-message is dropped, `chain_out` is unchanged, and the controller returns to ready. An engine done that arrives while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Abort request from the error logic |
| cfg_mode | input | 2 | Chaining mode (00 ECB, 01 CBC, 10 CTR) |
| cfg_wide | input | 1 | 1 selects the 128-bit engine, 0 the 64-bit engine |
| cfg_decrypt | input | 1 | Direction, 1 = decrypt |
| cfg_key | input | 128 | Cipher key |
| iv_load | input | 1 | Load the chaining register from iv_in |
| iv_in | input | 128 | Initial chaining or counter value |
| blk_valid | input | 1 | Input block offered |
| blk_in | input | 128 | Input block |
| blk_ready | output | 1 | Controller idle and able to accept a block |
| eom | input | 1 | End-of-message pulse |
| out_valid | output | 1 | Processed block valid (one cycle) |
| out_blk | output | 128 | Processed block |
| chain_out | output | 128 | Chaining register contents |
| msg_done | output | 1 | Message complete, context safe to read |
| irq | output | 1 | One-cycle interrupt request on completion |
| n_start | output | 1 | 64-bit engine start |
| n_decrypt | output | 1 | 64-bit engine direction |
| n_key | output | 64 | 64-bit engine key |
| n_in | output | 64 | 64-bit engine input block |
| n_done | input | 1 | 64-bit engine done |
| n_out | input | 64 | 64-bit engine result |
| w_start | output | 1 | 128-bit engine start |
| w_decrypt | output | 1 | 128-bit engine direction |
| w_key | output | 128 | 128-bit engine key |
| w_in | output | 128 | 128-bit engine input block |
| w_done | input | 1 | 128-bit engine done |
| w_out | input | 128 | 128-bit engine result |

## Verification
The assertions watch several rules on every cycle. At most one engine is started, and the idle engine's key and block stay at zero. A start never lasts two cycles, and CTR never launches a decrypt. A narrow result has a zero upper half. A halt is never followed by a result, and completion is never flagged while a block is in flight. The bench has to show the chaining arithmetic itself: CBC feedback in both directions, counter wrap at both widths, and the exact cycle on which completion rises after an end-of-message that arrives busy or idle. It also checks that a block offered while busy or aborted by halt leaves no trace on the outputs or on the chaining register.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    typedef enum logic [1:0] {
        MODE_ECB = 2'b00,
        MODE_CBC = 2'b01,
        MODE_CTR = 2'b10,
        MODE_RSV = 2'b11
    } chain_mode_e;

endpackage

// File: rtl/cmc_pre.sv
// Forms the engine input and direction for a block at acceptance time.
module cmc_pre
    import cmc_pkg::*;
#(
    parameter int WIDE_W   = 128,
    parameter int NARROW_W = 64
) (
    input  chain_mode_e       mode,
    input  logic              wide,
    input  logic              dec,
    input  logic [WIDE_W-1:0] blk,
    input  logic [WIDE_W-1:0] chain,
    output logic [WIDE_W-1:0] blk_m,
    output logic [WIDE_W-1:0] eng_in,
    output logic              eng_dec
);
    localparam logic [WIDE_W-1:0] NMASK = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    always_comb begin
        blk_m = wide ? blk : (blk & NMASK);
        unique case (mode)
            MODE_CBC: begin
                eng_in  = dec ? blk_m : (blk_m ^ chain);
                eng_dec = dec;
            end
            MODE_CTR: begin
                eng_in  = chain;
                eng_dec = 1'b0;
            end
            default: begin
                eng_in  = blk_m;
                eng_dec = dec;
            end
        endcase
    end
endmodule

// File: rtl/cmc_post.sv
// Combines the engine result with chaining state once the engine finishes.
module cmc_post
    import cmc_pkg::*;
#(
    parameter int WIDE_W   = 128,
    parameter int NARROW_W = 64
) (
    input  chain_mode_e       mode,
    input  logic              wide,
    input  logic              dec,
    input  logic [WIDE_W-1:0] blk_q,
    input  logic [WIDE_W-1:0] chain_q,
    input  logic [WIDE_W-1:0] eng_out,
    output logic [WIDE_W-1:0] res,
    output logic [WIDE_W-1:0] chain_nx
);
    localparam int HI_W = WIDE_W - NARROW_W;

    logic [WIDE_W-1:0] ctr_nx;

    generate
        if (HI_W > 0) begin : g_split
            always_comb begin
                if (wide)
                    ctr_nx = chain_q + {{(WIDE_W-1){1'b0}}, 1'b1};
                else
                    ctr_nx = {{HI_W{1'b0}}, chain_q[NARROW_W-1:0] + {{(NARROW_W-1){1'b0}}, 1'b1}};
            end
        end else begin : g_same
            always_comb ctr_nx = chain_q + {{(WIDE_W-1){1'b0}}, 1'b1};
        end
    endgenerate

    always_comb begin
        res      = eng_out;
        chain_nx = chain_q;
        unique case (mode)
            MODE_CBC: begin
                if (dec) begin
                    res      = eng_out ^ chain_q;
                    chain_nx = blk_q;
                end else begin
                    chain_nx = eng_out;
                end
            end
            MODE_CTR: begin
                res      = blk_q ^ eng_out;
                chain_nx = ctr_nx;
            end
            default: res = eng_out;
        endcase
    end
endmodule

// File: rtl/cmc_route.sv
// Steers launch, key and block to the selected engine and picks its result.
module cmc_route #(
    parameter int WIDE_W   = 128,
    parameter int NARROW_W = 64
) (
    input  logic                wide,
    input  logic                start,
    input  logic                dec,
    input  logic [WIDE_W-1:0]   key,
    input  logic [WIDE_W-1:0]   eng_in,
    output logic                n_start,
    output logic                n_decrypt,
    output logic [NARROW_W-1:0] n_key,
    output logic [NARROW_W-1:0] n_in,
    input  logic                n_done,
    input  logic [NARROW_W-1:0] n_out,
    output logic                w_start,
    output logic                w_decrypt,
    output logic [WIDE_W-1:0]   w_key,
    output logic [WIDE_W-1:0]   w_in,
    input  logic                w_done,
    input  logic [WIDE_W-1:0]   w_out,
    output logic                sel_done,
    output logic [WIDE_W-1:0]   sel_out
);
    always_comb begin
        n_start   = start & ~wide;
        n_decrypt = dec & ~wide;
        n_key     = wide ? '0 : key[NARROW_W-1:0];
        n_in      = wide ? '0 : eng_in[NARROW_W-1:0];
        w_start   = start & wide;
        w_decrypt = dec & wide;
        w_key     = wide ? key : '0;
        w_in      = wide ? eng_in : '0;
        sel_done  = wide ? w_done : n_done;
        sel_out   = wide ? w_out : {{(WIDE_W-NARROW_W){1'b0}}, n_out};
    end
endmodule

// File: rtl/chain_mode_ctrl.sv
module chain_mode_ctrl
    import cmc_pkg::*;
#(
    parameter int WIDE_W   = 128,
    parameter int NARROW_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt,
    input  logic [1:0]          cfg_mode,
    input  logic                cfg_wide,
    input  logic                cfg_decrypt,
    input  logic [WIDE_W-1:0]   cfg_key,
    input  logic                iv_load,
    input  logic [WIDE_W-1:0]   iv_in,
    input  logic                blk_valid,
    input  logic [WIDE_W-1:0]   blk_in,
    output logic                blk_ready,
    input  logic                eom,
    output logic                out_valid,
    output logic [WIDE_W-1:0]   out_blk,
    output logic [WIDE_W-1:0]   chain_out,
    output logic                msg_done,
    output logic                irq,
    output logic                n_start,
    output logic                n_decrypt,
    output logic [NARROW_W-1:0] n_key,
    output logic [NARROW_W-1:0] n_in,
    input  logic                n_done,
    input  logic [NARROW_W-1:0] n_out,
    output logic                w_start,
    output logic                w_decrypt,
    output logic [WIDE_W-1:0]   w_key,
    output logic [WIDE_W-1:0]   w_in,
    input  logic                w_done,
    input  logic [WIDE_W-1:0]   w_out
);
    localparam logic [WIDE_W-1:0] NMASK = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic              busy;
        logic              start;
        logic              wide;
        logic              dec;
        chain_mode_e       mode;
        logic [WIDE_W-1:0] key;
        logic [WIDE_W-1:0] blk;
        logic [WIDE_W-1:0] eng_in;
        logic              eng_dec;
        logic [WIDE_W-1:0] chain;
        logic              ovalid;
        logic [WIDE_W-1:0] oblk;
        logic              eom_pend;
        logic              done;
        logic              irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WIDE_W-1:0] pre_blk_m, pre_in, post_res, post_chain, sel_out;
    logic              pre_dec, sel_done, accept;

    cmc_pre #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_pre (
        .mode    (chain_mode_e'(cfg_mode)),
        .wide    (cfg_wide),
        .dec     (cfg_decrypt),
        .blk     (blk_in),
        .chain   (ctl_q.chain),
        .blk_m   (pre_blk_m),
        .eng_in  (pre_in),
        .eng_dec (pre_dec)
    );

    cmc_post #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_post (
        .mode     (ctl_q.mode),
        .wide     (ctl_q.wide),
        .dec      (ctl_q.dec),
        .blk_q    (ctl_q.blk),
        .chain_q  (ctl_q.chain),
        .eng_out  (sel_out),
        .res      (post_res),
        .chain_nx (post_chain)
    );

    cmc_route #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_route (
        .wide      (ctl_q.wide),
        .start     (ctl_q.start),
        .dec       (ctl_q.eng_dec),
        .key       (ctl_q.key),
        .eng_in    (ctl_q.eng_in),
        .n_start   (n_start),
        .n_decrypt (n_decrypt),
        .n_key     (n_key),
        .n_in      (n_in),
        .n_done    (n_done),
        .n_out     (n_out),
        .w_start   (w_start),
        .w_decrypt (w_decrypt),
        .w_key     (w_key),
        .w_in      (w_in),
        .w_done    (w_done),
        .w_out     (w_out),
        .sel_done  (sel_done),
        .sel_out   (sel_out)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.start  = 1'b0;
        ctl_d.ovalid = 1'b0;
        ctl_d.irq    = 1'b0;
        accept       = !ctl_q.busy && blk_valid && !halt && !iv_load;

        if (halt) begin
            ctl_d.busy     = 1'b0;
            ctl_d.eom_pend = 1'b0;
        end else if (ctl_q.busy) begin
            if (sel_done && !ctl_q.start) begin
                ctl_d.busy   = 1'b0;
                ctl_d.ovalid = 1'b1;
                ctl_d.oblk   = post_res;
                ctl_d.chain  = post_chain;
            end
            if (eom) ctl_d.eom_pend = 1'b1;
        end else if (iv_load) begin
            ctl_d.chain    = cfg_wide ? iv_in : (iv_in & NMASK);
            ctl_d.done     = 1'b0;
            ctl_d.eom_pend = 1'b0;
        end else if (accept) begin
            ctl_d.busy    = 1'b1;
            ctl_d.start   = 1'b1;
            ctl_d.wide    = cfg_wide;
            ctl_d.dec     = cfg_decrypt;
            ctl_d.mode    = chain_mode_e'(cfg_mode);
            ctl_d.key     = cfg_wide ? cfg_key : (cfg_key & NMASK);
            ctl_d.blk     = pre_blk_m;
            ctl_d.eng_in  = pre_in;
            ctl_d.eng_dec = pre_dec;
            ctl_d.done    = 1'b0;
            if (eom) ctl_d.eom_pend = 1'b1;
        end else if (ctl_q.eom_pend) begin
            ctl_d.done     = 1'b1;
            ctl_d.irq      = 1'b1;
            ctl_d.eom_pend = 1'b0;
        end else if (eom) begin
            ctl_d.eom_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign blk_ready = !ctl_q.busy;
    assign out_valid = ctl_q.ovalid;
    assign out_blk   = ctl_q.oblk;
    assign chain_out = ctl_q.chain;
    assign msg_done  = ctl_q.done;
    assign irq       = ctl_q.irq;

    a_r2_one_engine: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({n_start, w_start}));
    a_r2_narrow_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        n_start |-> (w_in == '0 && w_key == '0));
    a_r2_wide_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        w_start |-> (n_in == '0 && n_key == '0));
    a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        (n_start || w_start) |=> !(n_start || w_start));
    a_r3_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_ready && !halt && !iv_load) |=> (n_start || w_start));
    a_r4_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ctl_q.wide) |-> (out_blk[WIDE_W-1:NARROW_W] == '0));
    a_r7_ctr_encrypt: assert property (@(posedge clk) disable iff (!rst_n)
        ((n_start || w_start) && ctl_q.mode == MODE_CTR) |-> !(n_decrypt || w_decrypt));
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |-> blk_ready);
    a_r10_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> msg_done);
    a_r11_halt_abort: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!out_valid && blk_ready && !msg_done));
endmodule

// File: tb/sim_chain_mode_ctrl.sv
module sim_chain_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] KEY  = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [127:0] KC   = 128'h5A3C_96E1_0F87_D24B_A5C3_691E_F078_2DB4;
    localparam logic [127:0] IVB  = 128'hC0FF_EE00_1122_3344_5566_7788_99AA_BBCC;
    localparam logic [127:0] MASK_N = {64'h0, {64{1'b1}}};

    // {reload, mode[1:0], wide, dec, data[127:0]}
    localparam logic [132:0] VEC [12] = '{
        {1'b1, 2'b00, 1'b1, 1'b0, 128'h1111_2222_3333_4444_5555_6666_7777_8888},
        {1'b0, 2'b11, 1'b1, 1'b1, 128'hDEAD_BEEF_0000_FFFF_1234_5678_9ABC_DEF0},
        {1'b1, 2'b01, 1'b1, 1'b0, 128'h0F0F_0F0F_F0F0_F0F0_AAAA_5555_CCCC_3333},
        {1'b0, 2'b01, 1'b1, 1'b0, 128'h8000_0000_0000_0001_7FFF_FFFF_FFFF_FFFE},
        {1'b1, 2'b01, 1'b1, 1'b1, 128'h2468_ACE0_1357_9BDF_FDB9_7531_0ECA_8642},
        {1'b0, 2'b01, 1'b1, 1'b1, 128'h0000_0000_0000_0000_0000_0000_0000_0001},
        {1'b1, 2'b10, 1'b1, 1'b0, 128'h9999_8888_7777_6666_5555_4444_3333_2222},
        {1'b0, 2'b10, 1'b1, 1'b1, 128'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF_0000},
        {1'b1, 2'b00, 1'b0, 1'b0, 128'hBAD0_BAD0_BAD0_BAD0_0123_4567_89AB_CDEF},
        {1'b1, 2'b01, 1'b0, 1'b0, 128'hFFFF_FFFF_FFFF_FFFF_1357_2468_1357_2468},
        {1'b0, 2'b01, 1'b0, 1'b1, 128'h1234_0000_0000_4321_CAFE_F00D_BEEF_D00D},
        {1'b1, 2'b10, 1'b0, 1'b0, 128'h7777_7777_7777_7777_0000_1111_2222_3333}
    };

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic         rst_n, halt, cfg_wide, cfg_decrypt, iv_load, blk_valid, eom;
    logic [1:0]   cfg_mode;
    logic [127:0] cfg_key, iv_in, blk_in, out_blk, chain_out, w_key, w_in, w_out;
    logic         blk_ready, out_valid, msg_done, irq;
    logic         n_start, n_decrypt, n_done, w_start, w_decrypt, w_done;
    logic [63:0]  n_key, n_in, n_out;

    chain_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .halt(halt), .cfg_mode(cfg_mode), .cfg_wide(cfg_wide),
        .cfg_decrypt(cfg_decrypt), .cfg_key(cfg_key), .iv_load(iv_load), .iv_in(iv_in),
        .blk_valid(blk_valid), .blk_in(blk_in), .blk_ready(blk_ready), .eom(eom),
        .out_valid(out_valid), .out_blk(out_blk), .chain_out(chain_out),
        .msg_done(msg_done), .irq(irq),
        .n_start(n_start), .n_decrypt(n_decrypt), .n_key(n_key), .n_in(n_in),
        .n_done(n_done), .n_out(n_out),
        .w_start(w_start), .w_decrypt(w_decrypt), .w_key(w_key), .w_in(w_in),
        .w_done(w_done), .w_out(w_out)
    );

    function automatic logic [127:0] ref_eng(input logic [127:0] x, input logic [127:0] k,
                                             input logic wide, input logic dec);
        logic [127:0] m, y;
        m = wide ? '1 : MASK_N;
        if (!dec) begin
            y = (x ^ k) & m;
            y = wide ? {y[124:0], y[127:125]} : {64'h0, y[60:0], y[63:61]};
            y = y ^ (KC & m);
        end else begin
            y = (x ^ KC) & m;
            y = wide ? {y[2:0], y[127:3]} : {64'h0, y[2:0], y[63:3]};
            y = (y ^ k) & m;
        end
        return y;
    endfunction

    // keyed stub engines: 64-bit latency 3, 128-bit latency 5
    logic [2:0]   ncnt, wcnt;
    logic [63:0]  nd, nk;
    logic [127:0] wd, wk, n_full;
    logic         ndec, wdec;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ncnt <= 0; wcnt <= 0;
        end else begin
            if (n_start) begin ncnt <= 3; nd <= n_in; nk <= n_key; ndec <= n_decrypt; end
            else if (ncnt != 0) ncnt <= ncnt - 1;
            if (w_start) begin wcnt <= 5; wd <= w_in; wk <= w_key; wdec <= w_decrypt; end
            else if (wcnt != 0) wcnt <= wcnt - 1;
        end
    end
    assign n_done = (ncnt == 1);
    assign w_done = (wcnt == 1);
    assign n_full = ref_eng({64'h0, nd}, {64'h0, nk}, 1'b0, ndec);
    assign n_out  = n_full[63:0];
    assign w_out  = ref_eng(wd, wk, 1'b1, wdec);

    int n_checks = 0, n_fail = 0;
    int n_starts = 0, w_starts = 0, route_bad = 0, ctr_bad = 0, busy_done_bad = 0;
    logic [127:0] mchain;

    always @(posedge clk) begin
        if (rst_n) begin
            if (n_start) n_starts++;
            if (w_start) w_starts++;
            if (n_start && (w_in != 0 || w_key != 0 || w_start)) route_bad++;
            if (w_start && (n_in != 0 || n_key != 0)) route_bad++;
            if ((n_start || w_start) && cfg_mode == 2'b10 && (n_decrypt || w_decrypt)) ctr_bad++;
            if (msg_done && !blk_ready) busy_done_bad++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    task automatic load_iv(input logic [127:0] iv, input logic wide);
        @(negedge clk);
        cfg_wide = wide; iv_in = iv; iv_load = 1'b1;
        @(negedge clk);
        iv_load = 1'b0;
        mchain = wide ? iv : (iv & MASK_N);
    endtask

    task automatic model_step(input logic [1:0] mode, input logic wide, input logic dec,
                              input logic [127:0] blk, output logic [127:0] res);
        logic [127:0] m, b, k, c;
        m = wide ? '1 : MASK_N;
        b = blk & m; k = KEY & m; c = mchain;
        case (mode)
            2'b01: if (!dec) begin res = ref_eng(b ^ c, k, wide, 1'b0); mchain = res; end
                   else begin res = (ref_eng(b, k, wide, 1'b1) ^ c) & m; mchain = b; end
            2'b10: begin
                res = b ^ ref_eng(c, k, wide, 1'b0);
                mchain = wide ? c + 128'h1 : {64'h0, c[63:0] + 64'h1};
            end
            default: res = ref_eng(b, k, wide, dec);
        endcase
    endtask

    // offer one block, return the first result seen
    task automatic run_blk(input logic [1:0] mode, input logic wide, input logic dec,
                           input logic [127:0] blk, input bit eom_busy,
                           output logic [127:0] got, output bit seen);
        @(negedge clk);
        cfg_mode = mode; cfg_wide = wide; cfg_decrypt = dec; blk_in = blk; blk_valid = 1'b1;
        @(negedge clk);
        blk_valid = 1'b0;
        if (eom_busy) begin eom = 1'b1; @(negedge clk); eom = 1'b0; end
        seen = 0; got = '0;
        for (int i = 0; i < 60; i++) begin
            if (out_valid) begin seen = 1; got = out_blk; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [127:0] got, exp, iv;
        bit seen;
        int ns0, ws0;
        rst_n = 0; halt = 0; cfg_wide = 0; cfg_decrypt = 0; iv_load = 0; blk_valid = 0;
        eom = 0; cfg_mode = 0; cfg_key = KEY; iv_in = 0; blk_in = 0; mchain = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(blk_ready && !out_valid && !msg_done && !irq, "R1 idle flags",
            {124'h0, blk_ready, out_valid, msg_done, irq}, 128'h8);
        chk(chain_out == 0, "R1 chain", chain_out, 0);
        chk(n_starts == 0 && w_starts == 0, "R1 no start", n_starts + w_starts, 0);

        // vector table
        for (int i = 0; i < 12; i++) begin
            logic       rl, wd_, dc;
            logic [1:0] md;
            logic [127:0] dt;
            {rl, md, wd_, dc, dt} = VEC[i];
            if (rl) begin
                iv = IVB ^ 128'(i);
                load_iv(iv, wd_);
                chk(chain_out == mchain, "R9 iv load", chain_out, mchain);
            end
            ns0 = n_starts; ws0 = w_starts;
            run_blk(md, wd_, dc, dt, 1'b0, got, seen);
            model_step(md, wd_, dc, dt, exp);
            chk(seen && got == exp,
                md == 2'b01 ? "R6 cbc result" : (md == 2'b10 ? "R7 ctr result" : "R5 ecb result"),
                got, exp);
            chk(chain_out == mchain, "R8 chain with output", chain_out, mchain);
            chk((wd_ ? (w_starts - ws0) : (n_starts - ns0)) == 1 &&
                (wd_ ? (n_starts - ns0) : (w_starts - ws0)) == 0,
                "R3 one start on selected engine", 128'(n_starts - ns0), 128'(w_starts - ws0));
            if (!wd_) chk(got[127:64] == 0 && chain_out[127:64] == 0, "R4 upper zero",
                          {got[127:64], chain_out[127:64]}, 0);
            @(negedge clk);
            chk(!out_valid, "R8 valid one cycle", {127'h0, out_valid}, 0);
        end

        // R3 block offered while busy is ignored
        load_iv(IVB, 1'b1);
        ws0 = w_starts;
        @(negedge clk);
        cfg_mode = 2'b00; cfg_wide = 1; cfg_decrypt = 0; blk_in = 128'hA1; blk_valid = 1;
        @(negedge clk);
        blk_in = 128'hB2;
        repeat (2) @(negedge clk);
        blk_valid = 0;
        seen = 0;
        for (int i = 0; i < 60 && !seen; i++) begin
            if (out_valid) begin seen = 1; got = out_blk; end
            else @(negedge clk);
        end
        exp = ref_eng(128'hA1, KEY, 1'b1, 1'b0);
        chk(seen && got == exp, "R3 busy offer ignored", got, exp);
        repeat (8) @(negedge clk);
        chk(w_starts - ws0 == 1, "R3 single start", 128'(w_starts - ws0), 1);

        // R7 counter wrap, narrow and wide
        load_iv({64'hA5A5_A5A5_A5A5_A5A5, 64'hFFFF_FFFF_FFFF_FFFF}, 1'b0);
        chk(chain_out == {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, "R4 iv masked", chain_out, mchain);
        run_blk(2'b10, 1'b0, 1'b0, 128'h55, 1'b0, got, seen);
        model_step(2'b10, 1'b0, 1'b0, 128'h55, exp);
        chk(seen && got == exp, "R7 narrow wrap result", got, exp);
        chk(chain_out == 0, "R7 narrow wrap", chain_out, 0);
        load_iv('1, 1'b1);
        run_blk(2'b10, 1'b1, 1'b0, 128'h66, 1'b0, got, seen);
        model_step(2'b10, 1'b1, 1'b0, 128'h66, exp);
        chk(seen && got == exp, "R7 wide wrap result", got, exp);
        chk(chain_out == 0, "R7 wide wrap", chain_out, 0);

        // R10 eom arriving while busy
        load_iv(IVB, 1'b1);
        run_blk(2'b00, 1'b1, 1'b0, 128'h77, 1'b1, got, seen);
        chk(seen && !msg_done, "R10 not done with last output", {127'h0, msg_done}, 0);
        @(negedge clk);
        chk(msg_done && irq, "R10 done after busy eom", {126'h0, msg_done, irq}, 3);
        @(negedge clk);
        chk(msg_done && !irq, "R10 irq one cycle", {126'h0, msg_done, irq}, 2);
        load_iv(IVB, 1'b1);
        chk(!msg_done, "R9 iv load clears done", {127'h0, msg_done}, 0);

        // R10 eom while idle
        @(negedge clk); eom = 1;
        @(negedge clk); eom = 0;
        chk(!msg_done, "R10 idle eom first edge", {127'h0, msg_done}, 0);
        @(negedge clk);
        chk(msg_done && irq, "R10 idle eom second edge", {126'h0, msg_done, irq}, 3);
        @(negedge clk);
        cfg_mode = 2'b00; cfg_wide = 1; blk_in = 128'h9; blk_valid = 1;
        @(negedge clk); blk_valid = 0;
        chk(!msg_done, "R10 new block clears done", {127'h0, msg_done}, 0);
        repeat (10) @(negedge clk);

        // R11 halt mid-flight with pending eom
        load_iv(IVB ^ 128'h5, 1'b1);
        @(negedge clk);
        cfg_mode = 2'b01; cfg_wide = 1; cfg_decrypt = 0; blk_in = 128'hC3; blk_valid = 1;
        @(negedge clk); blk_valid = 0; eom = 1;
        @(negedge clk); eom = 0; halt = 1;
        @(negedge clk); halt = 0;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (out_valid) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R11 no output after halt", {127'h0, seen}, 0);
        chk(blk_ready && !msg_done, "R11 idle, eom dropped", {126'h0, blk_ready, msg_done}, 2);
        chk(chain_out == mchain, "R11 chain unchanged", chain_out, mchain);
        run_blk(2'b01, 1'b1, 1'b0, 128'hC3, 1'b0, got, seen);
        model_step(2'b01, 1'b1, 1'b0, 128'hC3, exp);
        chk(seen && got == exp, "R11 recovers after halt", got, exp);

        chk(route_bad == 0, "R2 unselected engine quiet", 128'(route_bad), 0);
        chk(ctr_bad == 0, "R7 ctr encrypt only", 128'(ctr_bad), 0);
        chk(busy_done_bad == 0, "R10 done only when idle", 128'(busy_done_bad), 0);
        summary();
        $finish;
    end
endmodule